// File: doc/BRIEF.md
# Wired Interrupt Source Gateway

This block sits at the front of an interrupt controller. It handles a bank of wired interrupt lines. Each line first passes through a two-flop synchronizer. A per-source configuration register then turns the line into a rectified value: the line is dropped, passed through, or inverted, depending on a delegate flag and a mode code. From the rectified values the block keeps one pending bit and one enable bit per source. Sources in edge modes go pending on a rising rectified value. Sources in level modes track the rectified value. Detached sources go pending only through register writes.

Software reaches the block through a simple word-addressed write port and a combinational read port. Through these it can:
- write a source's configuration;
- set or clear pending bits 32 sources at a time;
- set one pending bit by source number;
- write enable masks;
- read back pending, enable and rectified words.

A configuration write takes effect on the same clock edge. If the new mode leaves the source active and its rectified input is already high, the source goes pending on that edge. A line that was raised before software configured it is therefore never lost.

Top module: `irq_src_gateway`

## Requirements
- R1: Source 0, and every source number at or above NUM_SRC, has a rectified value of 0 and never goes pending. Writes aimed at such sources, whether configuration, mask bits or set-by-number, change nothing. Their configuration reads back as 0.
- R2: When bit 10 (delegate) of a source's configuration is 1, the source is treated as inactive. Its rectified value is 0, and pending, enable and set writes have no effect on it.
- R3: Mode code 0 (off) makes a source inactive with a rectified value of 0. Reserved codes 2 and 3 do the same. The mode occupies bits [2:0].
- R4: For the active mode codes, the rectified value depends on the synchronized raw input as follows:
  - 1 (detached), 4 (rising edge) and 6 (level high): the rectified value equals the raw input.
  - 5 (falling edge) and 7 (level low): the rectified value is the raw input inverted.
- R5: A read at word address 0x460+w returns, in bit i, the rectified value of source w*32+i. A read at 0x400+w returns the pending bits of the same sources, and a read at 0x440+w returns their enable bits. A read at address n below 0x400 returns source n's configuration: delegate in bit 10, mode in bits [2:0].
- R6: A configuration write that leaves the source inactive clears its pending and enable bits on the edge that takes the write.
- R7: A configuration write that leaves the source active sets its pending bit on that same edge when the rectified value under the new configuration is 1. In a level mode, pending takes the new rectified value.
- R8: In edge modes, pending is set by a 0-to-1 change of the rectified value. A configuration write updates the stored previous value, so the write itself never produces an edge.
- R9: In level modes, pending equals the rectified value of the previous cycle. Writes that set or clear pending have no effect.
- R10: Three writes act on pending in edge and detached modes:
  - a 1 in bit i of a write to 0x400+w sets pending for source w*32+i;
  - a write of n in bits [9:0] to 0x480 sets pending for source n;
  - a 1 in bit i of a write to 0x420+w clears pending for source w*32+i.
  When a clear and an edge fall in the same cycle, the edge wins.
- R11: In detached mode the wire never sets pending. Only a configuration write (R7) or a set write (R10) does.
- R12: A raw input change reaches pending in a level mode on the third rising clock edge after it is applied, not earlier.
- R13: A write to 0x440+w loads bit i as the enable of source w*32+i, but only if that source is active; otherwise the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_irq | input | NUM_SRC | Raw interrupt wires; bit 0 is unused |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read word address |
| rd_data | output | 32 | Combinational read data |
| pending_o | output | NUM_SRC | Pending bit per source |
| enable_o | output | NUM_SRC | Enable bit per source |

## Verification
The hardest situation to reach is a line that is already high before its source is configured. Once a source is active, its pending bit depends on both edge history and configuration order, so this case needs a specific setup. Directed steps raise a wire while its source is off, then write a level-high configuration, and check that pending is set on the very edge of the write. Further directed steps check that an edge-mode write with a high line sets pending once and yields no second edge after pending is cleared. Random configuration, mask, number and wire changes then interleave, so that delegated, reserved and out-of-range sources keep meeting live wires and set writes.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

  localparam int ADDR_W    = 12;
  localparam int DELEG_POS = 10;

  localparam logic [ADDR_W-1:0] BASE_PEND_SET = 12'h400;
  localparam logic [ADDR_W-1:0] BASE_PEND_CLR = 12'h420;
  localparam logic [ADDR_W-1:0] BASE_EN       = 12'h440;
  localparam logic [ADDR_W-1:0] BASE_RECT     = 12'h460;
  localparam logic [ADDR_W-1:0] ADDR_SETNUM   = 12'h480;

  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_DETACH = 3'd1,
    SM_RSV2   = 3'd2,
    SM_RSV3   = 3'd3,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_HIGH   = 3'd6,
    SM_LOW    = 3'd7
  } src_mode_e;

  typedef struct packed {
    logic      deleg;
    src_mode_e mode;
  } src_cfg_t;

  function automatic src_cfg_t cfg_from_word(input logic [31:0] d);
    src_cfg_t c;
    c.deleg = d[DELEG_POS];
    c.mode  = src_mode_e'(d[2:0]);
    return c;
  endfunction

  function automatic logic cfg_active(input src_cfg_t c);
    if (c.deleg) return 1'b0;
    case (c.mode)
      SM_DETACH, SM_RISE, SM_FALL, SM_HIGH, SM_LOW: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_inverts(input src_mode_e m);
    return (m == SM_FALL) || (m == SM_LOW);
  endfunction

  function automatic logic mode_is_edge(input src_mode_e m);
    return (m == SM_RISE) || (m == SM_FALL);
  endfunction

  function automatic logic mode_is_level(input src_mode_e m);
    return (m == SM_HIGH) || (m == SM_LOW);
  endfunction

  function automatic logic rectify(input src_cfg_t c, input logic raw);
    return cfg_active(c) & (raw ^ mode_inverts(c.mode));
  endfunction

endpackage

// File: rtl/irq_gw_sync.sv
module irq_gw_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_r <= '0;
      q      <= '0;
    end else begin
      meta_r <= d;
      q      <= meta_r;
    end
  end
endmodule

// File: rtl/irq_gw_cell.sv
module irq_gw_cell
  import irq_gw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     raw_s,
  input  logic     cfg_we,
  input  src_cfg_t cfg_wd,
  input  logic     set_req,
  input  logic     clr_req,
  input  logic     en_we,
  input  logic     en_wd,
  output src_cfg_t cfg_q,
  output logic     rect_o,
  output logic     pend_o,
  output logic     en_o,
  output logic     act_o,
  output logic     edge_o,
  output logic     level_o
);
  logic prev_r;
  logic rect_new, act_new;

  always_comb begin
    act_o    = cfg_active(cfg_q);
    act_new  = cfg_active(cfg_wd);
    rect_o   = rectify(cfg_q, raw_s);
    rect_new = rectify(cfg_wd, raw_s);
    edge_o   = !cfg_we && act_o && mode_is_edge(cfg_q.mode) && rect_o && !prev_r;
    level_o  = !cfg_we && act_o && mode_is_level(cfg_q.mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{deleg: 1'b0, mode: SM_OFF};
      pend_o <= 1'b0;
      en_o   <= 1'b0;
      prev_r <= 1'b0;
    end else if (cfg_we) begin
      cfg_q  <= cfg_wd;
      prev_r <= rect_new;
      if (!act_new) begin
        pend_o <= 1'b0;
        en_o   <= 1'b0;
      end else if (mode_is_level(cfg_wd.mode)) begin
        pend_o <= rect_new;
      end else begin
        pend_o <= pend_o | rect_new;
      end
    end else begin
      prev_r <= rect_o;
      if (!act_o)                           pend_o <= 1'b0;
      else if (mode_is_level(cfg_q.mode))   pend_o <= rect_o;
      else                                  pend_o <= (pend_o & ~clr_req) | set_req | edge_o;
      if (en_we && act_o) en_o <= en_wd;
    end
  end
endmodule

// File: rtl/irq_gw_readback.sv
module irq_gw_readback
  import irq_gw_pkg::*;
#(
  parameter int VEC_W  = 64,
  parameter int NWORDS = 2
) (
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [VEC_W-1:0]       pend_v,
  input  logic [VEC_W-1:0]       en_v,
  input  logic [VEC_W-1:0]       rect_v,
  input  logic [VEC_W-1:0][3:0]  cfg_bits,
  output logic [31:0]            rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr[11:10] == 2'b00) begin
      for (int k = 0; k < VEC_W; k++) begin
        if (rd_addr[9:0] == 10'(k))
          rd_data = {21'd0, cfg_bits[k][3], 7'd0, cfg_bits[k][2:0]};
      end
    end else begin
      for (int k = 0; k < NWORDS; k++) begin
        if (rd_addr[4:0] == 5'(k)) begin
          if (rd_addr[11:5] == BASE_PEND_SET[11:5])  rd_data = pend_v[k*32 +: 32];
          else if (rd_addr[11:5] == BASE_EN[11:5])   rd_data = en_v[k*32 +: 32];
          else if (rd_addr[11:5] == BASE_RECT[11:5]) rd_data = rect_v[k*32 +: 32];
        end
      end
    end
  end
endmodule

// File: rtl/irq_src_gateway.sv
module irq_src_gateway
  import irq_gw_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raw_irq,
  input  logic               wr_en,
  input  logic [11:0]        wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [11:0]        rd_addr,
  output logic [31:0]        rd_data,
  output logic [NUM_SRC-1:0] pending_o,
  output logic [NUM_SRC-1:0] enable_o
);
  localparam int NWORDS = (NUM_SRC + 31) / 32;
  localparam int VEC_W  = NWORDS * 32;

  logic [NUM_SRC-2:0]     raw_s;
  logic [VEC_W-1:0]       pend_v, en_v, rect_v, act_v, edge_v, lvl_v;
  logic [VEC_W-1:0][3:0]  cfg_bits;
  logic                   cfg_hit, pset_hit, pclr_hit, en_hit, pnum_hit;
  logic                   unused_raw0;
  src_cfg_t               wcfg;

  assign unused_raw0 = raw_irq[0];

  irq_gw_sync #(.W(NUM_SRC-1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_irq[NUM_SRC-1:1]),
    .q    (raw_s)
  );

  always_comb begin
    wcfg     = cfg_from_word(wr_data);
    cfg_hit  = wr_en && (wr_addr[11:10] == 2'b00);
    pset_hit = wr_en && (wr_addr[11:5] == BASE_PEND_SET[11:5]);
    pclr_hit = wr_en && (wr_addr[11:5] == BASE_PEND_CLR[11:5]);
    en_hit   = wr_en && (wr_addr[11:5] == BASE_EN[11:5]);
    pnum_hit = wr_en && (wr_addr == ADDR_SETNUM);
  end

  for (genvar n = 0; n < VEC_W; n++) begin : g_src
    if (n >= 1 && n < NUM_SRC) begin : g_cell
      localparam int WI = n / 32;
      localparam int BI = n % 32;
      logic     wsel, sel_cfg, set_n, clr_n, en_n;
      src_cfg_t cq;

      assign wsel    = (wr_addr[4:0] == 5'(WI));
      assign sel_cfg = cfg_hit && (wr_addr[9:0] == 10'(n));
      assign set_n   = (pset_hit && wsel && wr_data[BI]) ||
                       (pnum_hit && (wr_data[9:0] == 10'(n)));
      assign clr_n   = pclr_hit && wsel && wr_data[BI];
      assign en_n    = en_hit && wsel;

      irq_gw_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_s  (raw_s[n-1]),
        .cfg_we (sel_cfg),
        .cfg_wd (wcfg),
        .set_req(set_n),
        .clr_req(clr_n),
        .en_we  (en_n),
        .en_wd  (wr_data[BI]),
        .cfg_q  (cq),
        .rect_o (rect_v[n]),
        .pend_o (pend_v[n]),
        .en_o   (en_v[n]),
        .act_o  (act_v[n]),
        .edge_o (edge_v[n]),
        .level_o(lvl_v[n])
      );
      assign cfg_bits[n] = cq;
    end else begin : g_tie
      assign rect_v[n]   = 1'b0;
      assign pend_v[n]   = 1'b0;
      assign en_v[n]     = 1'b0;
      assign act_v[n]    = 1'b0;
      assign edge_v[n]   = 1'b0;
      assign lvl_v[n]    = 1'b0;
      assign cfg_bits[n] = 4'd0;
    end
  end

  irq_gw_readback #(.VEC_W(VEC_W), .NWORDS(NWORDS)) u_rd (
    .rd_addr (rd_addr),
    .pend_v  (pend_v),
    .en_v    (en_v),
    .rect_v  (rect_v),
    .cfg_bits(cfg_bits),
    .rd_data (rd_data)
  );

  assign pending_o = pend_v[NUM_SRC-1:0];
  assign enable_o  = en_v[NUM_SRC-1:0];
endmodule

// File: rtl/irq_gw_checker.sv
module irq_gw_checker #(
  parameter int VEC_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VEC_W-1:0] pend_v,
  input logic [VEC_W-1:0] en_v,
  input logic [VEC_W-1:0] rect_v,
  input logic [VEC_W-1:0] act_v,
  input logic [VEC_W-1:0] edge_v,
  input logic [VEC_W-1:0] lvl_v
);
  // R2, R3: an inactive or delegated source never shows a high rectified value
  assert_rect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rect_v & ~act_v) == '0);

  // R6: a source that is not active holds no pending bit
  assert_pend_needs_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v & ~act_v) == '0);

  // R13: a source that is not active holds no enable bit
  assert_en_needs_active_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (en_v & ~act_v) == '0);

  // R8: a detected edge always leaves the source pending on the next cycle
  assert_edge_sets_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_v) |=> ((pend_v & $past(edge_v)) == $past(edge_v)));

  // R9: in level modes pending copies the rectified value one cycle later
  assert_level_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_v) |=> ((pend_v & $past(lvl_v)) == ($past(rect_v) & $past(lvl_v))));
endmodule

bind irq_src_gateway irq_gw_checker #(.VEC_W(VEC_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .pend_v(pend_v),
  .en_v  (en_v),
  .rect_v(rect_v),
  .act_v (act_v),
  .edge_v(edge_v),
  .lvl_v (lvl_v)
);

// File: tb/irq_src_gateway_tb.sv
module irq_src_gateway_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] raw_irq = '0;
  logic          wr_en = 1'b0;
  logic [11:0]   wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [11:0]   rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NS-1:0] pending_o, enable_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_cfg [NS];
  logic       m_pend[NS];
  logic       m_en  [NS];
  logic       m_raw [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_src_gateway #(.NUM_SRC(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .raw_irq(raw_irq),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pending_o(pending_o), .enable_o(enable_o)
  );

  // model: cfg nibble = {delegate, mode[2:0]}
  function automatic bit b_act(input logic [3:0] c);
    case (c[2:0])
      3'd1, 3'd4, 3'd5, 3'd6, 3'd7: return !c[3];
      default: return 1'b0;
    endcase
  endfunction
  function automatic bit b_level(input logic [3:0] c); return c[2] & c[1];  endfunction
  function automatic bit b_edge (input logic [3:0] c); return c[2] & !c[1]; endfunction
  function automatic bit b_rect(input logic [3:0] c, input logic r);
    if (!b_act(c)) return 1'b0;
    return (c[2] & c[0]) ? !r : r;
  endfunction

  function automatic void m_touch(input int n, input bit set, input bit clr);
    if (n < 1 || n >= NS) return;
    if (!b_act(m_cfg[n]) || b_level(m_cfg[n])) return;
    if (set) m_pend[n] = 1'b1;
    else if (clr) m_pend[n] = 1'b0;
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    if (a[11:10] == 2'b00) begin
      int n = int'(a[9:0]);
      if (n >= 1 && n < NS) begin
        logic [3:0] c = {d[10], d[2:0]};
        bit r = b_rect(c, m_raw[n]);
        m_cfg[n] = c;
        if (!b_act(c)) begin m_pend[n] = 0; m_en[n] = 0; end
        else if (b_level(c)) m_pend[n] = r;
        else if (r) m_pend[n] = 1;
      end
    end else if (a == 12'h480) begin
      m_touch(int'(d[9:0]), 1'b1, 1'b0);
    end else begin
      for (int i = 0; i < 32; i++) begin
        int n = int'(a[4:0]) * 32 + i;
        if (a[11:5] == 7'h20 && d[i]) m_touch(n, 1'b1, 1'b0);
        if (a[11:5] == 7'h21 && d[i]) m_touch(n, 1'b0, 1'b1);
        if (a[11:5] == 7'h22 && n >= 1 && n < NS && b_act(m_cfg[n])) m_en[n] = d[i];
      end
    end
  endfunction

  function automatic void model_raw(input logic [NS-1:0] v);
    for (int n = 1; n < NS; n++) begin
      bit o = b_rect(m_cfg[n], m_raw[n]);
      bit w = b_rect(m_cfg[n], v[n]);
      if (b_level(m_cfg[n]) && b_act(m_cfg[n])) m_pend[n] = w;
      else if (b_edge(m_cfg[n]) && !o && w) m_pend[n] = 1'b1;
      m_raw[n] = v[n];
    end
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic set_raw(input logic [NS-1:0] v);
    model_raw(v);
    @(negedge clk);
    raw_irq = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [63:0] ep, ee, er;
    logic [31:0] w0, w1, p0, p1, e0, e1;
    ep = '0; ee = '0; er = '0;
    for (int n = 1; n < NS; n++) begin
      ep[n] = m_pend[n];
      ee[n] = m_en[n];
      er[n] = b_rect(m_cfg[n], m_raw[n]);
    end
    chk({tag, " pending_o"}, 64'(pending_o), ep);
    chk({tag, " enable_o"},  64'(enable_o), ee);
    rd(12'h460, w0); rd(12'h461, w1);
    chk({tag, " R5 rect words"}, {w1, w0}, er);
    rd(12'h400, p0); rd(12'h401, p1);
    rd(12'h440, e0); rd(12'h441, e1);
    chk({tag, " R5 pend/en words"}, {p1 ^ e1, p0 ^ e0}, ep ^ ee);
  endtask

  task automatic chk_cfg(input string tag, input int n);
    logic [31:0] d, e;
    rd(12'(n), d);
    e = '0;
    if (n >= 1 && n < NS) begin e[10] = m_cfg[n][3]; e[2:0] = m_cfg[n][2:0]; end
    chk(tag, 64'(d), 64'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] rv;
    for (int n = 0; n < NS; n++) begin
      m_cfg[n] = '0; m_pend[n] = 0; m_en[n] = 0; m_raw[n] = 0;
    end
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R3 / R7: line high while off, then level-high config pends on the write edge
    set_raw(NS'(1) << 3);
    check_all("R3 off source ignores wire");
    wr(12'd3, 32'h6);
    chk("R7 pending at config edge", 64'(pending_o[3]), 64'd1);
    check_all("R7 after config");

    // R12: level source 5, count edges to pending
    wr(12'd5, 32'h6);
    model_raw(raw_irq | (NS'(1) << 5));
    @(negedge clk); raw_irq[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R12 not yet after two edges", 64'(pending_o[5]), 64'd0);
    @(negedge clk);
    chk("R12 pending after third edge", 64'(pending_o[5]), 64'd1);

    // R9: set/clear writes ignored in level mode
    wr(12'h420, 32'h20);
    check_all("R9 clear ignored in level");

    // R2: delegated level-high source with high wire
    set_raw(raw_irq | (NS'(1) << 7));
    wr(12'd7, 32'h406);
    wr(12'h480, 32'd7);
    wr(12'h440, 32'h80);
    check_all("R2 delegated stays quiet");
    chk_cfg("R5 R2 cfg readback", 7);

    // R1: out-of-range and source 0
    wr(12'h480, 32'd0);
    wr(12'h480, 32'd40);
    wr(12'h480, 32'd45);
    wr(12'd45, 32'h6);
    wr(12'h401, 32'hFFFF_FF00);
    check_all("R1 out of range");
    chk_cfg("R1 cfg of 45 reads 0", 45);

    // R8: edge mode with high wire pends once, no spurious edge after clear
    set_raw(raw_irq | (NS'(1) << 9));
    wr(12'd9, 32'h4);
    check_all("R8 R7 rise config with high wire");
    wr(12'h420, 32'h200);
    repeat (3) @(negedge clk);
    check_all("R8 no spurious edge");
    set_raw(raw_irq & ~(NS'(1) << 9));
    set_raw(raw_irq | (NS'(1) << 9));
    check_all("R8 real edge");

    // R11: detached ignores wire, obeys number write
    wr(12'd11, 32'h1);
    set_raw(raw_irq | (NS'(1) << 11));
    check_all("R11 wire ignored");
    wr(12'h480, 32'd11);
    check_all("R10 R11 set by number");

    // R4 / R6 / R13: falling-edge + enable, then switch off
    wr(12'd12, 32'h5);
    wr(12'h440, 32'h1000);
    check_all("R4 R13 falling config");
    wr(12'd12, 32'h2);
    check_all("R6 reserved clears");

    for (int it = 0; it < 250; it++) begin
      int k = int'($urandom % 6);
      case (k)
        0: begin
          int n = int'($urandom % 48);
          logic [31:0] d = ($urandom & 32'h3F8) | ($urandom % 8);
          if ($urandom % 4 == 0) d[10] = 1'b1; else d[10] = 1'b0;
          wr(12'(n), d);
          check_all("R6 R7 random cfg");
          chk_cfg("R1 R5 random cfg readback", n);
        end
        1: begin wr(12'h400 | 12'($urandom % 3), $urandom); check_all("R10 random set mask"); end
        2: begin wr(12'h420 | 12'($urandom % 3), $urandom); check_all("R10 random clr mask"); end
        3: begin wr(12'h480, $urandom % 48); check_all("R10 random set num"); end
        4: begin wr(12'h440 | 12'($urandom % 3), $urandom); check_all("R13 random enable"); end
        default: begin
          rv = NS'({$urandom, $urandom});
          set_raw(rv);
          check_all("R4 R8 R9 random wires");
        end
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule